// File: doc/BRIEF.md
# Flash Program-Access Fault Checker

This block sits in front of a flash array and screens every write aimed at it during program or erase. A write request carries an address, a byte-lane size code and up to 64 bits of data. The block judges it against three inputs: the programming configuration (parallelism size, program enable, erase enable) and a per-sector write-protection mask. A request that passes is forwarded to the array as a single-cycle pulse. A counter of configurable length then stands in for the array's program or erase time.

A request that fails is dropped. Each of the four fault kinds has its own sticky flag: bad sequence, parallelism mismatch, 128-bit row overflow and write-protected target. A summary operation-error flag sets alongside any of them. A busy flag covers the check cycle and the array time, and it aborts as soon as a fault is found. An end-of-operation flag marks each clean completion. The flags appear in a status word at register offset 0x0C. Software clears each flag by writing 1 to it.

Top module: `fpe_checker`

## Requirements
- R1: After reset the status word reads 0, busy is 0, wr_ready is 1 and no array pulse is issued.
- R2: Status word layout: bit 16 busy, bit 7 sequence fault, bit 6 parallelism fault, bit 5 row fault, bit 4 protection fault, bit 1 operation error, bit 0 end of operation. Every other bit reads 0. Any word offset other than 0x0C reads 0.
- R3: A request is accepted on a clock edge where wr_valid and wr_ready are both 1. Busy rises in the next cycle. A clean access keeps busy high for exactly OP_CYCLES+1 cycles. wr_ready is low while busy, and a request held during that time waits without raising any flag.
- R4: The sequence fault sets when program enable and erase enable are equal, that is both 0 or both 1.
- R5: In program mode (program enable 1, erase enable 0), the parallelism fault sets when the size code differs from the configured size code. Both use the encoding 0 byte, 1 half-word, 2 word, 3 double word.
- R6: In program mode, the row fault sets when the low four address bits plus the access byte count (1 << size) exceed 16.
- R7: In program or erase mode, the protection fault sets when bit addr[ADDR_W-1:SECT_SHIFT] of wp_mask is 1.
- R8: On a faulty access, all matching fault flags and the operation-error flag set in the same cycle. Busy lasts exactly one cycle. Nothing is forwarded to the array and end of operation does not set.
- R9: A clean access produces exactly one array pulse that carries the accepted address, size and data, with arr_erase equal to the erase enable. End of operation sets when busy falls.
- R10: A write to offset 0x0C with byte-enable bit 0 set clears the flags whose bits are 1 in the data. Data bits of 0, writes without byte-enable bit 0, and writes to other offsets change nothing.
- R11: When hardware sets a flag in the same cycle that software writes 1 to it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Block can take a request |
| wr_addr | input | ADDR_W | Byte address of the request |
| wr_size | input | 2 | Access size code |
| wr_data | input | DATA_W | Write data |
| cfg_psize | input | 2 | Configured programming size code |
| cfg_prog_en | input | 1 | Program enable |
| cfg_erase_en | input | 1 | Erase enable |
| wp_mask | input | 2**(ADDR_W-SECT_SHIFT) | Per-sector write-protect bits |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_be | input | 4 | Register byte enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| busy | output | 1 | Operation in progress |
| arr_wr_valid | output | 1 | One-cycle forward pulse to the array |
| arr_wr_addr | output | ADDR_W | Forwarded address |
| arr_wr_size | output | 2 | Forwarded size code |
| arr_wr_data | output | DATA_W | Forwarded data |
| arr_erase | output | 1 | Forwarded operation is an erase |

## Verification
The bench targets row-boundary accesses such as a double word at offset 8, which fits, and one at offset 9, which does not. A checker with an off-by-one comparison would flag the first or pass the second. It stacks several faults on one access so that a design which sets only the first matching flag, or still forwards the write, shows up. It collides a software clear with a hardware set on the same edge, which exposes a clear-wins priority. It also holds a request against busy, which catches a design that accepts early or flags the stalled request. Randomized accesses then compare busy length, forward pulses and flags against a bench model.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } fpe_state_e;

  typedef struct packed {
    logic seq;
    logic par;
    logic aln;
    logic wpr;
  } fpe_fault_t;

  // status bit positions
  localparam int STAT_EOP   = 0;
  localparam int STAT_OPERR = 1;
  localparam int STAT_WPR   = 4;
  localparam int STAT_ALN   = 5;
  localparam int STAT_PAR   = 6;
  localparam int STAT_SEQ   = 7;
  localparam int STAT_BUSY  = 16;

  localparam int ROW_AW = 4;  // 128-bit row = 16 bytes

  // byte count of an access size code
  function automatic logic [ROW_AW:0] size_bytes(input logic [1:0] sz);
    return (ROW_AW+1)'(1) << sz;
  endfunction

  // access spills past the end of its row
  function automatic logic crosses_row(input logic [ROW_AW-1:0] off,
                                       input logic [1:0] sz);
    return ({1'b0, off} + size_bytes(sz)) > (ROW_AW+1)'(1 << ROW_AW);
  endfunction

endpackage

// File: rtl/fpe_access_check.sv
module fpe_access_check
  import fpe_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int SECT_SHIFT = 14,
  localparam int NUM_SECT  = 1 << (ADDR_W - SECT_SHIFT)
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          size,
  input  logic [1:0]          psize,
  input  logic                prog_en,
  input  logic                erase_en,
  input  logic [NUM_SECT-1:0] wp_mask,
  output fpe_fault_t          fault,
  output logic                any_fault
);

  logic mode_bad;
  logic prog_mode;
  logic sect_locked;

  assign mode_bad    = (prog_en == erase_en);
  assign prog_mode   = prog_en & ~erase_en;
  assign sect_locked = wp_mask[addr[ADDR_W-1:SECT_SHIFT]];

  always_comb begin
    fault.seq = mode_bad;
    fault.wpr = ~mode_bad & sect_locked;
    fault.par = prog_mode & (size != psize);
    fault.aln = prog_mode & crosses_row(addr[ROW_AW-1:0], size);
  end

  assign any_fault = |fault;

endmodule

// File: rtl/fpe_op_seq.sv
module fpe_op_seq
  import fpe_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 64,
  parameter int OP_CYCLES = 6,
  localparam int CNT_W    = $clog2(OP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        cfg_psize,
  input  logic              cfg_prog_en,
  input  logic              cfg_erase_en,
  input  logic              any_fault,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [1:0]        hold_size,
  output logic [1:0]        hold_psize,
  output logic              hold_prog,
  output logic              hold_erase,
  output logic              chk_fire,
  output logic              op_done,
  output logic              busy,
  output logic              arr_wr_valid,
  output logic [DATA_W-1:0] arr_wr_data
);

  fpe_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fwd_q;
  logic             accept;

  assign accept   = wr_valid & wr_ready;
  assign wr_ready = (state_q == ST_IDLE);
  assign busy     = (state_q != ST_IDLE);
  assign chk_fire = (state_q == ST_CHECK);
  assign op_done  = (state_q == ST_RUN) && (cnt_q == CNT_W'(1));
  assign arr_wr_valid = fwd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      fwd_q       <= 1'b0;
      hold_addr   <= '0;
      hold_size   <= '0;
      hold_psize  <= '0;
      hold_prog   <= 1'b0;
      hold_erase  <= 1'b0;
      arr_wr_data <= '0;
    end else begin
      fwd_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q     <= ST_CHECK;
            hold_addr   <= wr_addr;
            hold_size   <= wr_size;
            hold_psize  <= cfg_psize;
            hold_prog   <= cfg_prog_en;
            hold_erase  <= cfg_erase_en;
            arr_wr_data <= wr_data;
          end
        end
        ST_CHECK: begin
          if (any_fault) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_RUN;
            cnt_q   <= CNT_W'(OP_CYCLES);
            fwd_q   <= 1'b1;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done && !(chk_fire && any_fault)) |=> busy);

  a_r9_forward_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fire && !any_fault) |=> arr_wr_valid);

  a_r8_drop_faulty: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fire && any_fault) |=> (!arr_wr_valid && !busy));

endmodule

// File: rtl/fpe_status_reg.sv
module fpe_status_reg
  import fpe_pkg::*;
#(
  parameter int REG_AW      = 4,
  parameter int STAT_OFFSET = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_vld,
  input  fpe_fault_t        fault,
  input  logic              eop_set,
  input  logic              busy,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam logic [7:0]  FLAG_MASK = 8'hF3;
  localparam logic [31:0] READ_MASK = 32'h0001_00F3;
  localparam logic [REG_AW-3:0] STAT_WORD = (REG_AW-2)'(STAT_OFFSET >> 2);

  logic [7:0] flags_q;
  logic [7:0] set_vec;
  logic [7:0] clr_vec;
  logic       sel;
  logic       unused_bits;

  assign sel = (reg_addr[REG_AW-1:2] == STAT_WORD);
  assign unused_bits = ^{reg_addr[1:0], reg_be[3:1], reg_wdata[31:8]};

  always_comb begin
    set_vec             = '0;
    set_vec[STAT_SEQ]   = fault_vld & fault.seq;
    set_vec[STAT_PAR]   = fault_vld & fault.par;
    set_vec[STAT_ALN]   = fault_vld & fault.aln;
    set_vec[STAT_WPR]   = fault_vld & fault.wpr;
    set_vec[STAT_OPERR] = fault_vld & (|fault);
    set_vec[STAT_EOP]   = eop_set;
  end

  assign clr_vec = (reg_wr_en && sel && reg_be[0]) ? (reg_wdata[7:0] & FLAG_MASK) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

  always_comb begin
    reg_rdata = '0;
    if (sel) begin
      reg_rdata[7:0]       = flags_q;
      reg_rdata[STAT_BUSY] = busy;
    end
  end

  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 8'h00) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != 8'h00) |=> ((flags_q & $past(clr_vec & ~set_vec)) == 8'h00));

  a_r8_operr_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && (|fault)) |=> flags_q[STAT_OPERR]);

  a_r9_eop_follows: assert property (@(posedge clk) disable iff (!rst_n)
    eop_set |=> flags_q[STAT_EOP]);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~READ_MASK) == 32'h0);

endmodule

// File: rtl/fpe_checker.sv
module fpe_checker
  import fpe_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 64,
  parameter int SECT_SHIFT  = 14,
  parameter int OP_CYCLES   = 6,
  parameter int REG_AW      = 4,
  parameter int STAT_OFFSET = 12,
  localparam int NUM_SECT   = 1 << (ADDR_W - SECT_SHIFT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [1:0]          wr_size,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [1:0]          cfg_psize,
  input  logic                cfg_prog_en,
  input  logic                cfg_erase_en,
  input  logic [NUM_SECT-1:0] wp_mask,
  input  logic                reg_wr_en,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [3:0]          reg_be,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                busy,
  output logic                arr_wr_valid,
  output logic [ADDR_W-1:0]   arr_wr_addr,
  output logic [1:0]          arr_wr_size,
  output logic [DATA_W-1:0]   arr_wr_data,
  output logic                arr_erase
);

  logic [ADDR_W-1:0] hold_addr;
  logic [1:0]        hold_size;
  logic [1:0]        hold_psize;
  logic              hold_prog;
  logic              hold_erase;
  logic              chk_fire;
  logic              op_done;
  logic              any_fault;
  fpe_fault_t        fault;

  fpe_op_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_CYCLES(OP_CYCLES)
  ) u_seq (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_addr, .wr_size, .wr_data,
    .cfg_psize, .cfg_prog_en, .cfg_erase_en, .any_fault,
    .hold_addr, .hold_size, .hold_psize, .hold_prog, .hold_erase,
    .chk_fire, .op_done, .busy, .arr_wr_valid, .arr_wr_data
  );

  fpe_access_check #(
    .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT)
  ) u_chk (
    .addr(hold_addr), .size(hold_size), .psize(hold_psize),
    .prog_en(hold_prog), .erase_en(hold_erase), .wp_mask,
    .fault, .any_fault
  );

  fpe_status_reg #(
    .REG_AW(REG_AW), .STAT_OFFSET(STAT_OFFSET)
  ) u_stat (
    .clk, .rst_n, .fault_vld(chk_fire), .fault, .eop_set(op_done), .busy,
    .reg_wr_en, .reg_addr, .reg_be, .reg_wdata, .reg_rdata
  );

  assign arr_wr_addr = hold_addr;
  assign arr_wr_size = hold_size;
  assign arr_erase   = hold_erase;

  a_r9_fwd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_valid |-> busy);

endmodule

// File: tb/test_fpe_checker.sv
module test_fpe_checker;

  localparam int ADDR_W = 18, DATA_W = 64, SECT_SHIFT = 14, OP_CYCLES = 6, REG_AW = 4;
  localparam int NUM_SECT = 1 << (ADDR_W - SECT_SHIFT);

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [1:0] wr_size = '0, cfg_psize = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic cfg_prog_en = 0, cfg_erase_en = 0;
  logic [NUM_SECT-1:0] wp_mask = '0;
  logic reg_wr_en = 0;
  logic [REG_AW-1:0] reg_addr = 4'hC;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic busy, arr_wr_valid, arr_erase;
  logic [ADDR_W-1:0] arr_wr_addr;
  logic [1:0] arr_wr_size;
  logic [DATA_W-1:0] arr_wr_data;

  always #2 clk = ~clk;

  fpe_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_SHIFT(SECT_SHIFT),
                .OP_CYCLES(OP_CYCLES), .REG_AW(REG_AW)) i_fpe_checker (
    .clk, .rst_n, .wr_valid, .wr_ready, .wr_addr, .wr_size, .wr_data,
    .cfg_psize, .cfg_prog_en, .cfg_erase_en, .wp_mask,
    .reg_wr_en, .reg_addr, .reg_be, .reg_wdata, .reg_rdata,
    .busy, .arr_wr_valid, .arr_wr_addr, .arr_wr_size, .arr_wr_data, .arr_erase);

  int n_vec = 0, n_bad = 0;
  int busy_cnt, arr_cnt;
  logic [ADDR_W-1:0] cap_addr;
  logic [1:0] cap_size;
  logic [DATA_W-1:0] cap_data;
  logic cap_erase;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bench model of the flags one access leaves behind
  function automatic logic [31:0] model_flags(input int a, input int sz, input int ps,
                                              input bit p, input bit e, input int wp);
    logic [31:0] r = 0;
    int bytes = 1 << sz;
    if (p == e) r |= 32'h80;
    else begin
      if ((wp >> (a / (1 << SECT_SHIFT))) & 1) r |= 32'h10;
      if (p && sz != ps) r |= 32'h40;
      if (p && (a % 16) + bytes > 16) r |= 32'h20;
    end
    return (r != 0) ? (r | 32'h02) : 32'h01;
  endfunction

  task automatic read_stat(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
    reg_addr = 4'hC;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0; reg_addr = 4'hC; reg_be = 0; reg_wdata = 0;
  endtask

  task automatic setup(input int a, input int sz, input logic [63:0] d, input int ps,
                       input bit p, input bit e, input int wp);
    wr_addr = ADDR_W'(a); wr_size = 2'(sz); wr_data = d; cfg_psize = 2'(ps);
    cfg_prog_en = p; cfg_erase_en = e; wp_mask = NUM_SECT'(wp);
  endtask

  task automatic run_access(input int a, input int sz, input logic [63:0] d, input int ps,
                            input bit p, input bit e, input int wp);
    int guard = 0;
    @(negedge clk);
    chk("R3 ready when idle", wr_ready, 1);
    setup(a, sz, d, ps, p, e, wp);
    wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
    busy_cnt = 0; arr_cnt = 0;
    while (busy && guard < 100) begin
      busy_cnt++; guard++;
      if (arr_wr_valid) begin
        arr_cnt++; cap_addr = arr_wr_addr; cap_size = arr_wr_size;
        cap_data = arr_wr_data; cap_erase = arr_erase;
      end
      @(negedge clk);
    end
    if (arr_wr_valid) arr_cnt++;
  endtask

  task automatic check_access(input string tag, input int a, input int sz, input logic [63:0] d,
                              input int ps, input bit p, input bit e, input int wp);
    logic [31:0] exp, st;
    exp = model_flags(a, sz, ps, p, e, wp);
    run_access(a, sz, d, ps, p, e, wp);
    read_stat(4'hC, st);
    chk({tag, " R4-7 flags"}, st, exp);
    chk({tag, " R2 reserved"}, st & ~32'h0001_00F3, 0);
    if (exp[0]) begin
      chk({tag, " R3 busy length"}, busy_cnt, OP_CYCLES + 1);
      chk({tag, " R9 one pulse"}, arr_cnt, 1);
      chk({tag, " R9 fwd fields"}, {cap_addr, cap_size, cap_erase, cap_data[15:0]},
          {ADDR_W'(a), 2'(sz), e, d[15:0]});
      chk({tag, " R9 fwd data"}, cap_data, d);
    end else begin
      chk({tag, " R8 busy length"}, busy_cnt, 1);
      chk({tag, " R8 no pulse"}, arr_cnt, 0);
    end
  endtask

  task automatic clear_all();
    logic [31:0] st;
    reg_write(4'hC, 4'h1, 32'hFF);
    read_stat(4'hC, st);
    chk("R10 clear all", st, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] st;
    void'($urandom(32'h5EED_0123));
    repeat (3) @(posedge clk);
    @(negedge clk);
    read_stat(4'hC, st);
    chk("R1 status after reset", st, 0);
    chk("R1 busy/ready/pulse", {busy, wr_ready, arr_wr_valid}, 3'b010);
    @(negedge clk) rst_n = 1;

    // directed
    check_access("clean word",  'h00100, 2, 64'h1122334455667788, 2, 1, 0, 0); clear_all();
    check_access("R4 none",     'h00100, 2, 64'h1, 2, 0, 0, 0);                clear_all();
    check_access("R4 both",     'h00100, 2, 64'h1, 2, 1, 1, 0);                clear_all();
    check_access("R5 par",      'h00100, 0, 64'h1, 2, 1, 0, 0);                clear_all();
    check_access("R6 fits",     'h00008, 3, 64'hA5, 3, 1, 0, 0);               clear_all();
    check_access("R6 over",     'h00009, 3, 64'hA5, 3, 1, 0, 0);               clear_all();
    check_access("R7 erase",    'h0C000, 2, 64'h0, 2, 0, 1, 'h0008);           clear_all();
    check_access("R7 erase ok", 'h10000, 2, 64'h7, 2, 0, 1, 'h0008);           clear_all();
    check_access("R8 multi",    'h0C00C, 3, 64'h9, 1, 1, 0, 'h0008);

    // R10: no-effect writes, then a partial clear
    reg_write(4'hC, 4'hF, 32'h0);
    read_stat(4'hC, st); chk("R10 zero write", st, 32'h72);
    reg_write(4'hC, 4'hE, 32'hFF);
    read_stat(4'hC, st); chk("R10 no byte0 enable", st, 32'h72);
    reg_write(4'h8, 4'hF, 32'hFF);
    read_stat(4'hC, st); chk("R10 other offset", st, 32'h72);
    read_stat(4'h8, st); chk("R2 other offset reads 0", st, 0);
    reg_write(4'hC, 4'h1, 32'h40);
    read_stat(4'hC, st); chk("R10 partial clear", st, 32'h32);
    clear_all();

    // R11: clear lands on the edge that sets the same flags
    check_access("R11 preset", 'h0, 2, 64'h0, 2, 0, 0, 0);
    @(negedge clk);
    setup('h0, 2, 64'h0, 2, 0, 0, 0);
    wr_valid = 1;
    @(negedge clk);
    wr_valid = 0;
    reg_wr_en = 1; reg_be = 4'h1; reg_wdata = 32'h82; reg_addr = 4'hC;
    @(negedge clk);
    reg_wr_en = 0; reg_be = 0; reg_wdata = 0;
    repeat (2) @(negedge clk);
    read_stat(4'hC, st); chk("R11 set wins", st, 32'h82);
    clear_all();

    // R3: request held against busy
    begin
      int stalled = 0, early = 0;
      @(negedge clk);
      setup('h00200, 2, 64'h55, 2, 1, 0, 0);
      wr_valid = 1;
      @(negedge clk);
      setup('h00200, 2, 64'h55, 2, 0, 0, 0);
      while (!wr_ready) begin
        stalled++;
        if (reg_rdata[7:1] != 0) early++;
        @(negedge clk);
      end
      @(negedge clk);
      wr_valid = 0;
      chk("R3 stall cycles", stalled, OP_CYCLES + 1);
      chk("R3 no flag while stalled", early, 0);
      repeat (3) @(negedge clk);
      read_stat(4'hC, st); chk("R3 stalled request later judged", st, 32'h83);
      clear_all();
    end

    // random
    for (int i = 0; i < 150; i++) begin
      int a, sz, ps, sel, wp;
      bit p, e;
      logic [63:0] d;
      logic [31:0] msk, exp;
      a  = $urandom % (1 << ADDR_W);
      if ($urandom % 3 == 0) a = (a & ~15) | (12 + $urandom % 4);
      sz = $urandom % 4;
      ps = ($urandom % 2) ? sz : $urandom % 4;
      sel = $urandom % 8;
      p = (sel < 4) || (sel == 7);
      e = (sel == 4) || (sel == 5) || (sel == 7);
      wp = ($urandom % 2) ? ($urandom % 65536) : 0;
      d = {$urandom, $urandom};
      exp = model_flags(a, sz, ps, p, e, wp);
      check_access("rand", a, sz, d, ps, p, e, wp);
      msk = $urandom % 256;
      reg_write(4'hC, 4'h1, msk);
      read_stat(4'hC, st);
      chk("R10 rand partial clear", st, exp & ~msk);
      clear_all();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule